// File: doc/BRIEF.md
# Serial Receiver with Per-Character Error Queue

This block is the receive half of a simple register-mapped UART. A programmable 12-bit divisor produces a tick at 16 times the bit rate. The receiver uses that tick to find start bits, to sample data bits at their centre, and to check optional parity and the stop bit. Each finished character enters a receive queue together with its own three error flags. The queue holds 16 entries, or one entry when it works as a single holding register.

The bus side sees the character at the head of the queue on a data port and removes it with a one-cycle read strobe. The error flags of the character just removed then appear on a status port, where they stay until the next read. This matches software that reads the data register first and the status register second. A single empty flag tells software whether anything is waiting. Dropping the enable input stops the receiver and clears the queue, so software can reprogram the line word and divisor safely.

Top module: `uart_rx_statq`

## Requirements
- R1: After reset `rx_empty_o` is 1, `rd_stat_o` is 0 and `rd_data_o` is 0.
- R2: The divisor is `{div_hi_i, div_lo_i}` (12 bits). One bit time lasts 16*(divisor+1) clock cycles.
- R3: The word length is taken from `lcr_i[6:5]`: 00 gives 5 bits, 01 gives 6, 10 gives 7 and 11 gives 8. Data arrives LSB first and is delivered right-aligned, with the unused upper bits at zero.
- R4: `lcr_i[1]` enables a parity bit after the data, and `lcr_i[2]` selects even parity (1) or odd parity (0). A mismatch sets status bit 1. With parity off, status bit 1 is never set.
- R5: A stop bit that is sampled low sets status bit 0 (framing error). The character is still queued.
- R6: A falling edge begins a start bit only if the line is still low at the 8th tick. A shorter low pulse is dropped and queues nothing.
- R7: With `lcr_i[4]`=1 the queue holds 16 characters and delivers them in arrival order.
- R8: With `lcr_i[4]`=0 the queue holds one character. Any character that arrives while it is occupied is lost.
- R9: A character that arrives while the queue is full is discarded. The next character that is accepted carries status bit 2 (overrun).
- R10: A read strobe on a non-empty queue removes the head entry, and on the next cycle `rd_stat_o` shows that entry's flags. `rd_stat_o` does not change without such a read.
- R11: While `ctrl_en_i` is 0 the queue is flushed, the receiver stays idle and line activity is ignored.
- R12: `rx_empty_o` is 1 exactly when no character is waiting. `rd_data_o` shows the head character whenever one is waiting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ctrl_en_i | input | 1 | 1 runs the receiver, 0 holds it idle and flushes the queue |
| lcr_i | input | 8 | Line word: [1] parity enable, [2] even parity, [4] queue enable, [6:5] word length |
| div_lo_i | input | 8 | Divisor bits 7:0 |
| div_hi_i | input | 4 | Divisor bits 11:8 |
| rx_i | input | 1 | Serial input line, idle high |
| rd_pop_i | input | 1 | Read strobe that removes the head character |
| rd_data_o | output | 8 | Head character |
| rd_stat_o | output | 3 | Flags of the last character removed: [0] framing, [1] parity, [2] overrun |
| rx_empty_o | output | 1 | 1 when no character is waiting |

## Verification
A wrong sample counter or bit counter makes a character appear at the data port with its bits shifted or cut short. This becomes visible at the first read after the stop bit, so a sweep over word lengths, parity modes and data patterns exposes it within one frame. A wrong queue pointer or a lost overrun marker shows up as out-of-order data, a missing character or a wrong status bit 2. These are seen while the bench drains a full queue and on the first character accepted after the queue was full. The glitch test, the test with the receiver disabled and the test with a large divisor check, through the empty flag and the data port, that nothing spurious or garbled was queued.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;

    localparam int DIV_W  = 12;
    localparam int DATA_W = 8;

    // Queued character: flags above data, flag order matches status port
    typedef struct packed {
        logic              ovr;
        logic              par;
        logic              frm;
        logic [DATA_W-1:0] data;
    } rx_entry_t;

    typedef enum logic [2:0] {
        RX_IDLE,
        RX_START,
        RX_DATA,
        RX_PARITY,
        RX_STOP
    } rx_state_e;

    typedef struct packed {
        logic [3:0] nbits;
        logic       par_en;
        logic       even;
        logic       q_en;
    } line_cfg_t;

    function automatic line_cfg_t decode_line(input logic [7:0] w);
        line_cfg_t c;
        c.nbits  = 4'd5 + {2'b00, w[6:5]};
        c.par_en = w[1];
        c.even   = w[2];
        c.q_en   = w[4];
        return c;
    endfunction

endpackage

// File: rtl/uart_baud_tick.sv
module uart_baud_tick #(
    parameter int DIV_W = 12
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic [DIV_W-1:0] divisor,
    output logic             tick_o
);
    logic [DIV_W-1:0] cnt_q;
    logic             wrap;

    assign wrap   = (cnt_q >= divisor);
    assign tick_o = en && wrap;

    always_ff @(posedge clk) begin
        if (rst || !en)
            cnt_q <= '0;
        else if (wrap)
            cnt_q <= '0;
        else
            cnt_q <= cnt_q + 1'b1;
    end
endmodule

// File: rtl/uart_rx_fsm.sv
module uart_rx_fsm
    import uart_rx_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      en,
    input  logic      tick,
    input  logic      rx_s,
    input  line_cfg_t cfg,
    output logic      push_o,
    output rx_entry_t entry_o
);
    localparam logic [3:0] MID_START = 4'd7;
    localparam logic [3:0] LAST_SMP  = 4'd15;

    rx_state_e          state_q;
    logic [3:0]         smp_q;
    logic [3:0]         bitn_q;
    logic [DATA_W-1:0]  shreg_q;
    logic               last_q;
    logic               perr_q;

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            state_q <= RX_IDLE;
            smp_q   <= '0;
            bitn_q  <= '0;
            shreg_q <= '0;
            last_q  <= 1'b1;
            perr_q  <= 1'b0;
            push_o  <= 1'b0;
            entry_o <= '0;
        end else begin
            push_o <= 1'b0;
            if (tick) begin
                last_q <= rx_s;
                case (state_q)
                    RX_IDLE: begin
                        smp_q <= '0;
                        if (last_q && !rx_s)
                            state_q <= RX_START;
                    end
                    RX_START: begin
                        smp_q <= smp_q + 1'b1;
                        if (smp_q == MID_START) begin
                            smp_q   <= '0;
                            bitn_q  <= '0;
                            shreg_q <= '0;
                            perr_q  <= 1'b0;
                            state_q <= rx_s ? RX_IDLE : RX_DATA;
                        end
                    end
                    RX_DATA: begin
                        smp_q <= smp_q + 1'b1;
                        if (smp_q == LAST_SMP) begin
                            smp_q   <= '0;
                            shreg_q <= {rx_s, shreg_q[DATA_W-1:1]};
                            bitn_q  <= bitn_q + 1'b1;
                            if (bitn_q == cfg.nbits - 4'd1)
                                state_q <= cfg.par_en ? RX_PARITY : RX_STOP;
                        end
                    end
                    RX_PARITY: begin
                        smp_q <= smp_q + 1'b1;
                        if (smp_q == LAST_SMP) begin
                            smp_q   <= '0;
                            perr_q  <= ((^shreg_q) ^ rx_s) != !cfg.even;
                            state_q <= RX_STOP;
                        end
                    end
                    RX_STOP: begin
                        smp_q <= smp_q + 1'b1;
                        if (smp_q == LAST_SMP) begin
                            push_o       <= 1'b1;
                            entry_o.data <= shreg_q >> (4'd8 - cfg.nbits);
                            entry_o.frm  <= !rx_s;
                            entry_o.par  <= perr_q;
                            entry_o.ovr  <= 1'b0;
                            state_q      <= RX_IDLE;
                        end
                    end
                    default: state_q <= RX_IDLE;
                endcase
            end
        end
    end
endmodule

// File: rtl/uart_rx_queue.sv
module uart_rx_queue
    import uart_rx_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int AW   = $clog2(DEPTH),
    localparam int CW   = AW + 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          flush,
    input  logic          hold_mode,
    input  logic          push,
    input  rx_entry_t     wdata,
    input  logic          pop,
    output rx_entry_t     head_o,
    output logic          empty_o,
    output logic [CW-1:0] count_o
);
    rx_entry_t     mem_q [DEPTH];
    logic [AW-1:0] wp_q, rp_q;
    logic [CW-1:0] cap;
    logic          full, lost_q, do_push, do_pop;
    rx_entry_t     wentry;

    assign cap     = hold_mode ? CW'(1) : CW'(DEPTH);
    assign full    = (count_o >= cap);
    assign empty_o = (count_o == '0);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty_o;
    assign head_o  = mem_q[rp_q];

    always_comb begin
        wentry     = wdata;
        wentry.ovr = lost_q;
    end

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            wp_q    <= '0;
            rp_q    <= '0;
            count_o <= '0;
            lost_q  <= 1'b0;
        end else begin
            if (push && full)
                lost_q <= 1'b1;
            else if (do_push)
                lost_q <= 1'b0;
            if (do_push)
                wp_q <= wp_q + 1'b1;
            if (do_pop)
                rp_q <= rp_q + 1'b1;
            count_o <= count_o + CW'(do_push) - CW'(do_pop);
        end
    end

    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst)
                mem_q[i] <= '0;
            else if (do_push && wp_q == AW'(i))
                mem_q[i] <= wentry;
        end
    end
endmodule

// File: rtl/uart_rx_statq.sv
module uart_rx_statq
    import uart_rx_pkg::*;
#(
    parameter int DEPTH   = 16,
    parameter int SYNC_FF = 2,
    localparam int CW     = $clog2(DEPTH) + 1
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        ctrl_en_i,
    input  logic [7:0]  lcr_i,
    input  logic [7:0]  div_lo_i,
    input  logic [3:0]  div_hi_i,
    input  logic        rx_i,
    input  logic        rd_pop_i,
    output logic [7:0]  rd_data_o,
    output logic [2:0]  rd_stat_o,
    output logic        rx_empty_o
);
    line_cfg_t         cfg;
    logic              tick;
    logic [SYNC_FF-1:0] sync_q;
    logic              rx_s;
    logic              push;
    rx_entry_t         push_entry;
    rx_entry_t         head;
    logic [CW-1:0]     q_count;
    logic              pop_ok;

    assign cfg    = decode_line(lcr_i);
    assign rx_s   = sync_q[SYNC_FF-1];
    assign pop_ok = rd_pop_i && !rx_empty_o;

    always_ff @(posedge clk) begin
        if (rst)
            sync_q <= '1;
        else
            sync_q <= {sync_q[SYNC_FF-2:0], rx_i};
    end

    uart_baud_tick #(.DIV_W(DIV_W)) u_tick (
        .clk     (clk),
        .rst     (rst),
        .en      (ctrl_en_i),
        .divisor ({div_hi_i, div_lo_i}),
        .tick_o  (tick)
    );

    uart_rx_fsm u_fsm (
        .clk     (clk),
        .rst     (rst),
        .en      (ctrl_en_i),
        .tick    (tick),
        .rx_s    (rx_s),
        .cfg     (cfg),
        .push_o  (push),
        .entry_o (push_entry)
    );

    uart_rx_queue #(.DEPTH(DEPTH)) u_queue (
        .clk       (clk),
        .rst       (rst),
        .flush     (!ctrl_en_i),
        .hold_mode (!cfg.q_en),
        .push      (push),
        .wdata     (push_entry),
        .pop       (rd_pop_i),
        .head_o    (head),
        .empty_o   (rx_empty_o),
        .count_o   (q_count)
    );

    assign rd_data_o = rx_empty_o ? 8'h00 : head.data;

    always_ff @(posedge clk) begin
        if (rst)
            rd_stat_o <= '0;
        else if (pop_ok)
            rd_stat_o <= {head.ovr, head.par, head.frm};
    end
endmodule

// File: rtl/uart_rx_checker.sv
module uart_rx_checker #(
    parameter int DEPTH = 16,
    parameter int CW    = 5
) (
    input logic          clk,
    input logic          rst,
    input logic          ctrl_en_i,
    input logic          rd_pop_i,
    input logic          rx_empty_o,
    input logic [2:0]    rd_stat_o,
    input logic [CW-1:0] q_count,
    input logic          push,
    input logic          push_par,
    input logic [7:0]    lcr_i
);
    AST_STAT_HOLD: assert property (@(posedge clk) disable iff (rst)
        !rd_pop_i |=> $stable(rd_stat_o)); // R10

    AST_DISABLE_FLUSH: assert property (@(posedge clk) disable iff (rst)
        !ctrl_en_i |=> rx_empty_o); // R11

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        q_count <= CW'(DEPTH)); // R7

    AST_NO_PAR_WHEN_OFF: assert property (@(posedge clk) disable iff (rst)
        push && !lcr_i[1] |-> !push_par); // R4

    AST_HOLD_ONE: assert property (@(posedge clk) disable iff (rst)
        !lcr_i[4] && $stable(lcr_i) && q_count <= CW'(1) |=> q_count <= CW'(1)); // R8
endmodule

bind uart_rx_statq uart_rx_checker #(.DEPTH(DEPTH), .CW(CW)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .ctrl_en_i  (ctrl_en_i),
    .rd_pop_i   (rd_pop_i),
    .rx_empty_o (rx_empty_o),
    .rd_stat_o  (rd_stat_o),
    .q_count    (q_count),
    .push       (push),
    .push_par   (push_entry.par),
    .lcr_i      (lcr_i)
);

// File: tb/uart_rx_statq_tb.sv
module uart_rx_statq_tb_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       ctrl_en_i = 1'b1;
    logic [7:0] lcr_i = 8'h70;
    logic [7:0] div_lo_i = 8'h00;
    logic [3:0] div_hi_i = 4'h0;
    logic       rx_i = 1'b1;
    logic       rd_pop_i = 1'b0;
    logic [7:0] rd_data_o;
    logic [2:0] rd_stat_o;
    logic       rx_empty_o;

    int checks = 0;
    int fails  = 0;
    int bp     = 16;

    always #5 clk = ~clk;

    uart_rx_statq dut_i (
        .clk(clk), .rst(rst), .ctrl_en_i(ctrl_en_i), .lcr_i(lcr_i),
        .div_lo_i(div_lo_i), .div_hi_i(div_hi_i), .rx_i(rx_i),
        .rd_pop_i(rd_pop_i), .rd_data_o(rd_data_o), .rd_stat_o(rd_stat_o),
        .rx_empty_o(rx_empty_o)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic hold_line(input logic v, input int n);
        rx_i = v;
        repeat (n) @(negedge clk);
    endtask

    // Frame with line word lcr_i; flip_par corrupts parity, stop_v is the stop level
    task automatic send(input logic [7:0] d, input bit flip_par, input logic stop_v);
        int nb = 5 + int'(lcr_i[6:5]);
        logic pb;
        hold_line(1'b0, bp);
        for (int i = 0; i < nb; i++) hold_line(d[i], bp);
        if (lcr_i[1]) begin
            pb = 1'b0;
            for (int i = 0; i < nb; i++) pb = pb ^ d[i];
            if (!lcr_i[2]) pb = ~pb;
            hold_line(pb ^ flip_par, bp);
        end
        hold_line(stop_v, bp);
        hold_line(1'b1, bp);
    endtask

    task automatic pop_chk(input string req, input int exp_d, input int exp_s);
        chk(req, int'(rx_empty_o), 0);
        chk(req, int'(rd_data_o), exp_d);
        rd_pop_i = 1'b1;
        @(negedge clk);
        rd_pop_i = 1'b0;
        chk(req, int'(rd_stat_o), exp_s);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk("R1", int'(rx_empty_o), 1);
        chk("R1", int'(rd_stat_o), 0);
        chk("R1", int'(rd_data_o), 0);

        // R3/R4/R12 sweep: word length x parity mode x patterns
        for (int wl = 0; wl < 4; wl++) begin
            for (int pm = 0; pm < 3; pm++) begin
                for (int k = 0; k < 5; k++) begin
                    logic [7:0] d = (k == 0) ? 8'h00 : (k == 1) ? 8'hFF : 8'(8'hA5 + k * 53);
                    int mask = (1 << (5 + wl)) - 1;
                    lcr_i = {1'b0, 2'(wl), 1'b1, 1'b0, (pm == 2), (pm != 0), 1'b0};
                    send(d, 1'b0, 1'b1);
                    pop_chk("R3", int'(d) & mask, 0);
                    chk("R12", int'(rx_empty_o), 1);
                end
                if (pm != 0) begin
                    send(8'h5A, 1'b1, 1'b1);
                    pop_chk("R4", 'h5A & ((1 << (5 + wl)) - 1), 3'b010);
                end
            end
        end

        // R5 framing error
        lcr_i = 8'h70;
        send(8'h81, 1'b0, 1'b0);
        pop_chk("R5", 'h81, 3'b001);

        // R6 short glitch
        hold_line(1'b0, 4);
        hold_line(1'b1, 3 * bp);
        chk("R6", int'(rx_empty_o), 1);
        send(8'h3C, 1'b0, 1'b1);
        pop_chk("R6", 'h3C, 0);

        // R8/R9 single holding register
        lcr_i = 8'h60;
        send(8'h11, 1'b0, 1'b1);
        send(8'h22, 1'b0, 1'b1);
        pop_chk("R8", 'h11, 0);
        chk("R8", int'(rx_empty_o), 1);
        send(8'h33, 1'b0, 1'b1);
        pop_chk("R9", 'h33, 3'b100);

        // R10 status holds without a read, even as new data arrives
        lcr_i = 8'h70;
        send(8'h44, 1'b0, 1'b1);
        chk("R10", int'(rd_stat_o), 3'b100);
        pop_chk("R10", 'h44, 0);

        // R7/R9 sixteen-deep queue, 17th lost
        for (int i = 0; i < 17; i++) send(8'(i * 7 + 1), 1'b0, 1'b1);
        for (int i = 0; i < 16; i++) pop_chk("R7", (i * 7 + 1) & 'hFF, 0);
        chk("R7", int'(rx_empty_o), 1);
        send(8'hE7, 1'b0, 1'b1);
        pop_chk("R9", 'hE7, 3'b100);

        // R11 disabled receiver ignores the line
        ctrl_en_i = 1'b0;
        send(8'h55, 1'b0, 1'b1);
        chk("R11", int'(rx_empty_o), 1);
        send(8'h66, 1'b0, 1'b1);
        ctrl_en_i = 1'b1;
        send(8'h77, 1'b0, 1'b1);
        pop_chk("R11", 'h77, 0);
        chk("R11", int'(rx_empty_o), 1);

        // R2 divisor: low field then high field
        ctrl_en_i = 1'b0;
        div_lo_i = 8'h03;
        @(negedge clk);
        ctrl_en_i = 1'b1;
        bp = 16 * 4;
        send(8'hC3, 1'b0, 1'b1);
        pop_chk("R2", 'hC3, 0);
        ctrl_en_i = 1'b0;
        div_lo_i = 8'h00;
        div_hi_i = 4'h1;
        @(negedge clk);
        ctrl_en_i = 1'b1;
        bp = 16 * 257;
        send(8'h96, 1'b0, 1'b1);
        pop_chk("R2", 'h96, 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule